// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Carry and Overflow Flags

This block performs the add and subtract family of a 64-bit fixed-point pipeline in one registered step. The requested form chooses the effective operands and the carry-in. The forms are plain add, subtract-from, carrying, extended (which takes the stored carry as carry-in), zero-extended and negate. Immediate instructions use the same codes, with the sign-extended or shifted immediate placed on operand B by the decoder.

The block keeps a 32-bit fixed-point exception word and a 4-bit condition field. The exception word holds a carry and a signed-overflow flag at the 64-bit boundary and at the 32-bit boundary, plus a sticky summary-overflow bit. Per-instruction controls decide which of these are written. The carry flags are written only by the carrying and extended forms. The overflow flags are written only when overflow-enable is set. The condition field is written only when the record bit is set. Its value comes from a signed 64-bit compare of the result with zero.

Top module: `int_addsub_flags`

## Requirements
- R1: While rst_ni is low, and after it is released until the first accepted operation, result_o, xer_o, cr_o and valid_o are all zero.
- R2: An operation presented with valid_i high produces result_o, and valid_o high, at the next rising edge. op_i codes map as follows: 0 = A+B, 1 = ~A+B+1, 2 = A+B (carrying), 3 = ~A+B+1 (carrying), 4 = A+B+CA, 5 = ~A+B+CA, 6 = A+CA, 7 = ~A+CA, 8 = ~A+1. Codes 9 to 15 behave as code 0.
- R3: CA (xer_o bit 29) is the carry out of bit 63 of the effective sum. CA32 (xer_o bit 18) is the carry out of bit 31. Both are written only by codes 2 to 7 and otherwise hold.
- R4: When oe_i is set, OV (xer_o bit 30) and OV32 (xer_o bit 19) are written with signed overflow of the 64-bit and 32-bit effective sums, including writes of 0. When oe_i is clear, both hold.
- R5: SO (xer_o bit 31) is set whenever an operation with oe_i set overflows at 64 bits. Only reset clears it.
- R6: With rc_i set, cr_o is written as {LT, GT, EQ, SO}: cr_o[3] = result below zero (signed), cr_o[2] = above zero, cr_o[1] = zero, cr_o[0] = SO after this operation's update. With rc_i clear, cr_o holds.
- R7: The extended forms (codes 4 to 7) use the CA value left by the previous operation, so back-to-back operations chain their carries.
- R8: xer_o bits other than 31, 30, 29, 19 and 18 always read zero.
- R9: While valid_i is low, result_o, xer_o and cr_o hold and valid_o is low the next cycle, whatever op_i, oe_i and rc_i carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation form code |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B or immediate |
| oe_i | input | 1 | Overflow-enable: write OV, OV32, SO |
| rc_i | input | 1 | Record: write the condition field |
| result_o | output | 64 | Registered result |
| valid_o | output | 1 | Result updated at the last edge |
| xer_o | output | 32 | Fixed-point exception word |
| cr_o | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The sum 0x7FFF_FFFF + 1 sets OV32 without OV, while 0x7FFF_FFFF_FFFF_FFFF + 1 sets both and exercises the sticky SO. All-ones plus one wraps to zero, giving CA and CA32 together with EQ; a low-half-only carry shows CA32 without CA. A 128-bit add built from a carrying form followed by an extended form proves the carry-in chain, and the subtract forms with equal operands show that the inverted operand path produces a carry. Negate of the most negative value, idle cycles with the controls raised, and a long pseudo-random mix check the enable gating against an independent signed-range model.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_SUBF   = 4'd1,
    OP_ADDC   = 4'd2,
    OP_SUBFC  = 4'd3,
    OP_ADDE   = 4'd4,
    OP_SUBFE  = 4'd5,
    OP_ADDZE  = 4'd6,
    OP_SUBFZE = 4'd7,
    OP_NEG    = 4'd8
  } op_e;

  localparam int XER_W   = 32;
  localparam int CR_W    = 4;
  localparam int SO_BIT  = 31;
  localparam int OV_BIT  = 30;
  localparam int CA_BIT  = 29;
  localparam int OV32_BIT = 19;
  localparam int CA32_BIT = 18;

  typedef struct packed {
    logic ca;
    logic ca32;
    logic ov;
    logic ov32;
  } flags_t;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_CA   = 2'd2
  } cin_sel_e;
endpackage

// File: rtl/addsub_opsel.sv
module addsub_opsel
  import addsub_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ca_i,
  output logic [W-1:0] ea_o,
  output logic [W-1:0] eb_o,
  output logic         cin_o,
  output logic         ca_wr_o
);
  logic     inv_a;
  logic     zero_b;
  cin_sel_e cin_sel;

  always_comb begin
    inv_a   = 1'b0;
    zero_b  = 1'b0;
    cin_sel = CIN_ZERO;
    ca_wr_o = 1'b0;
    case (op_i)
      OP_SUBF:   begin inv_a = 1'b1; cin_sel = CIN_ONE; end
      OP_ADDC:   begin ca_wr_o = 1'b1; end
      OP_SUBFC:  begin inv_a = 1'b1; cin_sel = CIN_ONE; ca_wr_o = 1'b1; end
      OP_ADDE:   begin cin_sel = CIN_CA; ca_wr_o = 1'b1; end
      OP_SUBFE:  begin inv_a = 1'b1; cin_sel = CIN_CA; ca_wr_o = 1'b1; end
      OP_ADDZE:  begin zero_b = 1'b1; cin_sel = CIN_CA; ca_wr_o = 1'b1; end
      OP_SUBFZE: begin inv_a = 1'b1; zero_b = 1'b1; cin_sel = CIN_CA; ca_wr_o = 1'b1; end
      OP_NEG:    begin inv_a = 1'b1; zero_b = 1'b1; cin_sel = CIN_ONE; end
      default:   ;
    endcase
  end

  assign ea_o = inv_a  ? ~a_i : a_i;
  assign eb_o = zero_b ? '0   : b_i;

  always_comb begin
    case (cin_sel)
      CIN_ONE: cin_o = 1'b1;
      CIN_CA:  cin_o = ca_i;
      default: cin_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/addsub_sum.sv
module addsub_sum
  import addsub_pkg::*;
#(
  parameter int W   = 64,
  parameter int LOW = 32
) (
  input  logic [W-1:0] ea_i,
  input  logic [W-1:0] eb_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output flags_t       flags_o
);
  localparam int HIW = W - LOW;

  logic [LOW:0] lo_sum;
  logic [HIW:0] hi_sum;

  // split adder: the segment boundary carry is CA32
  assign lo_sum = {1'b0, ea_i[LOW-1:0]} + {1'b0, eb_i[LOW-1:0]} + {{LOW{1'b0}}, cin_i};
  assign hi_sum = {1'b0, ea_i[W-1:LOW]} + {1'b0, eb_i[W-1:LOW]} + {{HIW{1'b0}}, lo_sum[LOW]};

  assign sum_o = {hi_sum[HIW-1:0], lo_sum[LOW-1:0]};

  assign flags_o.ca   = hi_sum[HIW];
  assign flags_o.ca32 = lo_sum[LOW];
  assign flags_o.ov   = (ea_i[W-1] == eb_i[W-1]) && (sum_o[W-1] != ea_i[W-1]);
  assign flags_o.ov32 = (ea_i[LOW-1] == eb_i[LOW-1]) && (sum_o[LOW-1] != ea_i[LOW-1]);
endmodule

// File: rtl/addsub_state.sv
module addsub_state
  import addsub_pkg::*;
#(
  parameter int W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             oe_i,
  input  logic             rc_i,
  input  logic             ca_wr_i,
  input  logic [W-1:0]     sum_i,
  input  flags_t           flags_i,
  output logic [W-1:0]     result_o,
  output logic             valid_o,
  output logic             ca_o,
  output logic [XER_W-1:0] xer_o,
  output logic [CR_W-1:0]  cr_o
);
  logic so_q, ov_q, ov32_q, ca_q, ca32_q;
  logic so_next;
  logic lt, gt, eq;

  assign so_next = so_q | (oe_i & flags_i.ov);
  assign lt      = $signed(sum_i) < 0;
  assign eq      = (sum_i == '0);
  assign gt      = !lt && !eq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
      so_q     <= 1'b0;
      ov_q     <= 1'b0;
      ov32_q   <= 1'b0;
      ca_q     <= 1'b0;
      ca32_q   <= 1'b0;
      cr_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= sum_i;
        if (ca_wr_i) begin
          ca_q   <= flags_i.ca;
          ca32_q <= flags_i.ca32;
        end
        if (oe_i) begin
          ov_q   <= flags_i.ov;
          ov32_q <= flags_i.ov32;
          so_q   <= so_next;
        end
        if (rc_i) cr_o <= {lt, gt, eq, so_next};
      end
    end
  end

  assign ca_o = ca_q;

  always_comb begin
    xer_o           = '0;
    xer_o[SO_BIT]   = so_q;
    xer_o[OV_BIT]   = ov_q;
    xer_o[CA_BIT]   = ca_q;
    xer_o[OV32_BIT] = ov32_q;
    xer_o[CA32_BIT] = ca32_q;
  end
endmodule

// File: rtl/int_addsub_flags.sv
module int_addsub_flags
  import addsub_pkg::*;
#(
  parameter int W   = 64,
  parameter int LOW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic [W-1:0]     opa_i,
  input  logic [W-1:0]     opb_i,
  input  logic             oe_i,
  input  logic             rc_i,
  output logic [W-1:0]     result_o,
  output logic             valid_o,
  output logic [XER_W-1:0] xer_o,
  output logic [CR_W-1:0]  cr_o
);
  logic [W-1:0] ea, eb, sum;
  logic         cin, ca_wr, ca_cur;
  flags_t       flags;

  addsub_opsel #(.W(W)) u_opsel (
    .op_i    (op_i),
    .a_i     (opa_i),
    .b_i     (opb_i),
    .ca_i    (ca_cur),
    .ea_o    (ea),
    .eb_o    (eb),
    .cin_o   (cin),
    .ca_wr_o (ca_wr)
  );

  addsub_sum #(.W(W), .LOW(LOW)) u_sum (
    .ea_i    (ea),
    .eb_i    (eb),
    .cin_i   (cin),
    .sum_o   (sum),
    .flags_o (flags)
  );

  addsub_state #(.W(W)) u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .oe_i     (oe_i),
    .rc_i     (rc_i),
    .ca_wr_i  (ca_wr),
    .sum_i    (sum),
    .flags_i  (flags),
    .result_o (result_o),
    .valid_o  (valid_o),
    .ca_o     (ca_cur),
    .xer_o    (xer_o),
    .cr_o     (cr_o)
  );
endmodule

// File: rtl/int_addsub_flags_chk.sv
module int_addsub_flags_chk #(
  parameter int W = 64
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [3:0]   op_i,
  input logic         oe_i,
  input logic         rc_i,
  input logic [W-1:0] result_o,
  input logic         valid_o,
  input logic         so_i,
  input logic         ov_i,
  input logic         ca_i,
  input logic         ov32_i,
  input logic         ca32_i,
  input logic [3:0]   cr_i
);
  logic carrying;
  assign carrying = (op_i >= 4'd2) && (op_i <= 4'd7);

  assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_ca_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || !carrying) |=> ($stable(ca_i) && $stable(ca32_i)));

  assert_ov_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || !oe_i) |=> ($stable(ov_i) && $stable(ov32_i) && $stable(so_i)));

  assert_so_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_i |=> so_i);

  assert_ov_implies_so_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_i |-> so_i);

  assert_cr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || !rc_i) |=> $stable(cr_i));

  assert_cr_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rc_i) |=> (cr_i[3] == result_o[W-1] && cr_i[1] == (result_o == '0)
                           && $countones(cr_i[3:1]) == 1 && cr_i[0] == so_i));

  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o)));
endmodule

bind int_addsub_flags int_addsub_flags_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .oe_i     (oe_i),
  .rc_i     (rc_i),
  .result_o (result_o),
  .valid_o  (valid_o),
  .so_i     (xer_o[31]),
  .ov_i     (xer_o[30]),
  .ca_i     (xer_o[29]),
  .ov32_i   (xer_o[19]),
  .ca32_i   (xer_o[18]),
  .cr_i     (cr_o)
);

// File: tb/int_addsub_flags_test.sv
`timescale 1ns/1ps
module int_addsub_flags_test;
  typedef struct {
    logic [63:0] res;
    logic [31:0] xer;
    logic [3:0]  cr;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [63:0] opa_i = '0, opb_i = '0;
  logic        oe_i = 1'b0, rc_i = 1'b0;
  logic [63:0] result_o;
  logic        valid_o;
  logic [31:0] xer_o;
  logic [3:0]  cr_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  item_t q[$];

  // reference state
  logic m_so = 0, m_ov = 0, m_ca = 0, m_ov32 = 0, m_ca32 = 0;
  logic [3:0]  m_cr = '0;
  logic [63:0] m_res = '0;

  always #10 clk = ~clk;

  int_addsub_flags uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i), .oe_i(oe_i), .rc_i(rc_i),
    .result_o(result_o), .valid_o(valid_o), .xer_o(xer_o), .cr_o(cr_o)
  );

  function automatic logic [31:0] m_xer();
    return {m_so, m_ov, m_ca, 9'd0, m_ov32, m_ca32, 18'd0};
  endfunction

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] code, input logic [63:0] a, input logic [63:0] b,
                       input logic oe, input logic rc, input string tag);
    logic [63:0] ea, eb;
    logic        cin, wr_ca;
    logic [65:0] u64, s64;
    logic [33:0] u32, s32;
    item_t it;
    @(negedge clk);
    valid_i = 1'b1; op_i = code; opa_i = a; opb_i = b; oe_i = oe; rc_i = rc;
    ea = a; eb = b; cin = 1'b0; wr_ca = 1'b0;
    case (code)
      4'd1: begin ea = ~a; cin = 1'b1; end
      4'd2: wr_ca = 1'b1;
      4'd3: begin ea = ~a; cin = 1'b1; wr_ca = 1'b1; end
      4'd4: begin cin = m_ca; wr_ca = 1'b1; end
      4'd5: begin ea = ~a; cin = m_ca; wr_ca = 1'b1; end
      4'd6: begin eb = '0; cin = m_ca; wr_ca = 1'b1; end
      4'd7: begin ea = ~a; eb = '0; cin = m_ca; wr_ca = 1'b1; end
      4'd8: begin ea = ~a; eb = '0; cin = 1'b1; end
      default: ;
    endcase
    u64 = {2'b00, ea} + {2'b00, eb} + {65'd0, cin};
    u32 = {2'b00, ea[31:0]} + {2'b00, eb[31:0]} + {33'd0, cin};
    s64 = {{2{ea[63]}}, ea} + {{2{eb[63]}}, eb} + {65'd0, cin};
    s32 = {{2{ea[31]}}, ea[31:0]} + {{2{eb[31]}}, eb[31:0]} + {33'd0, cin};
    m_res = u64[63:0];
    if (wr_ca) begin m_ca = u64[64]; m_ca32 = u32[32]; end
    if (oe) begin
      m_ov   = (s64[65:63] != 3'b000) && (s64[65:63] != 3'b111);
      m_ov32 = (s32[33:31] != 3'b000) && (s32[33:31] != 3'b111);
      if (m_ov) m_so = 1'b1;
    end
    if (rc) m_cr = {m_res[63], !m_res[63] && m_res != 0, m_res == 0, m_so};
    it.res = m_res; it.xer = m_xer(); it.cr = m_cr; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0; op_i = 4'd3; opa_i = '1; opb_i = 64'd1; oe_i = 1'b1; rc_i = 1'b1;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (q.size() == 0) begin
        check(1'b0, "R2 unexpected valid_o", "1", "0");
      end else begin
        item_t e;
        e = q.pop_front();
        check(result_o === e.res && xer_o === e.xer && cr_o === e.cr, e.tag,
              $sformatf("%h/%h/%h", result_o, xer_o, cr_o),
              $sformatf("%h/%h/%h", e.res, e.xer, e.cr));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(result_o === 0 && xer_o === 0 && cr_o === 0 && valid_o === 0, "R1 reset",
          $sformatf("%h/%h/%h/%b", result_o, xer_o, cr_o, valid_o), "0/0/0/0");
    rst_ni = 1'b1;
    @(negedge clk);
    check(result_o === 0 && xer_o === 0 && cr_o === 0 && valid_o === 0, "R1 after release",
          $sformatf("%h/%h/%h/%b", result_o, xer_o, cr_o, valid_o), "0/0/0/0");

    do_op(4'd0, 64'd5, 64'd7, 1, 1, "R2 add small");
    do_op(4'd0, 64'h7FFF_FFFF, 64'd1, 1, 1, "R4 ov32 only");
    do_op(4'd2, 64'hFFFF_FFFF, 64'd1, 0, 1, "R3 ca32 without ca");
    do_op(4'd2, '1, 64'd1, 0, 1, "R3 64-bit wrap");
    do_op(4'd0, '1, 64'd1, 0, 1, "R3 add keeps ca");
    do_op(4'd1, 64'd9, 64'd4, 1, 1, "R2 subf negative");
    do_op(4'd3, 64'd9, 64'd9, 1, 1, "R3 subfc equal carries");
    do_op(4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1, 1, "R5 ov sets so");
    do_op(4'd0, 64'd1, 64'd1, 1, 1, "R5 so sticky ov cleared");
    do_op(4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, "R4 oe off holds");
    // 128-bit chain
    do_op(4'd2, '1, 64'd2, 0, 0, "R7 chain low");
    do_op(4'd4, 64'd0, 64'd0, 0, 1, "R7 chain high");
    do_op(4'd6, 64'd10, 64'hDEAD, 0, 1, "R7 addze");
    do_op(4'd7, 64'd0, 64'hBEEF, 0, 1, "R7 subfze");
    do_op(4'd5, 64'd3, 64'd3, 0, 1, "R7 subfe");
    do_op(4'd8, 64'h8000_0000_0000_0000, 64'd5, 1, 1, "R2 neg min overflow");
    do_op(4'd8, 64'd0, 64'd5, 0, 1, "R6 neg zero eq");
    do_op(4'd12, 64'd2, 64'd3, 0, 1, "R2 spare code adds");
    do_op(4'd0, 64'd1, 64'd1, 0, 0, "R6 rc off holds");
    idle(3);
    do_op(4'd0, 64'd0, 64'd0, 0, 0, "R9 idle no change");
    for (int i = 0; i < 300; i++) begin
      do_op(4'($urandom_range(0, 15)), {$urandom, $urandom}, {$urandom, $urandom},
            1'($urandom), 1'($urandom), "R8 random mix");
      if (i % 37 == 0) idle(1);
    end
    idle(3);
    check(q.size() == 0, "R2 drained", $sformatf("%0d", q.size()), "0");
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule